// File: doc/BRIEF.md
# Privilege-Gated Counter Register Unit

This block is the slice of a core's machine-level control register space that owns the current privilege mode, the identification and status words, and two masks that decide which counters less privileged code may read. It also keeps three free-running counters: clock cycles, retired instructions and external time ticks. It answers register reads through a single access port that has a registered result.

The 32 counter indices are read-only views. Index 0 is the cycle count, index 1 is the time count and index 2 is the retired-instruction count. Indices 3 to 31 are performance counters, and each of them shows the cycle count. Whether a counter read is allowed depends on the mode held in the mode register. A refused read returns zero and raises no error. Writes to counters are dropped without any effect. An index outside the implemented space raises a flag one cycle later.

Top module: `csr_cnt_unit`

## Requirements
- R1: After reset, the mode register (index 32) reads 3 (machine mode). The identification registers read zero, and so do the cycle, time and retired-instruction counts.
- R2: After reset, the ISA identification register (index 33) reads `(2 << (XLEN-2)) | 0x14112D`. With XLEN = 64 this is 0x800000000014112D.
- R3: After reset, the status register (index 34) reads 0x0000000A00002000. This is the value 2 in bits 33:32 and in bits 35:34, the value 1 in bits 14:13, and zero in every other bit.
- R4: After reset, the supervisor-level enable mask (index 35) and the user-level enable mask (index 36) both read 0x7.
- R5: The index map is as follows. 0 is cycles, 1 is time, 2 is retired instructions, and 3 to 31 read the cycle count. 32 is the mode, 33 the ISA identification, 34 the status, 35 the supervisor-level mask and 36 the user-level mask. 37 to 39 are identification registers.
- R6: The mode is taken from bits 1:0 of the mode register. Mode 3 may read every counter. Mode 1 may read counter n only when bit n of index 35 is set. Mode 0 may read counter n only when bit n of index 36 is set. Mode 2 may read no counter. A refused read returns zero.
- R7: After reset, the cycle count rises by one on every clock. The time count rises once for each cycle in which `tick` is high. The retired count rises once for each cycle in which `retire` is high. Each count is CNT_W bits wide, wraps to zero and is read zero-extended.
- R8: A write to an index from 0 to 31 or from 37 to 39 has no effect. A write to an index from 32 to 36 stores all XLEN bits of `wr_data`.
- R9: An access (read or write) to an index of 40 or above sets `bad_idx` high in the next cycle. Such a read returns zero and such a write changes nothing. `bad_idx` is low after any cycle without such an access.
- R10: `rd_data` is updated one cycle after a cycle in which `rd_en` is high, and holds its value otherwise. A read and a write to the same index in the same cycle return the value from before the write.
- R11: Indices 37, 38 and 39 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_idx | input | IDX_W | Register index for this access |
| wr_data | input | XLEN | Data to write |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| retire | input | 1 | Pulse, one per retired instruction |
| tick | input | 1 | Pulse from the time base |
| rd_data | output | XLEN | Registered read result |
| bad_idx | output | 1 | Registered flag for an access outside the index space |

## Verification
The bench builds the block with XLEN = 64 and IDX_W = 6, and reduces CNT_W to 8. At this width all three counters wrap many times within a short run, so the wrap and the zero-extension of counter reads are exercised. Indices 40 to 63 remain reachable as out-of-range values. Random traffic writes arbitrary values into the mode register and both masks, so every mode, including the reserved mode 2, meets many mask patterns.

// File: rtl/csr_cnt_pkg.sv
package csr_cnt_pkg;
   typedef enum logic [1:0] {
      MODE_USER  = 2'd0,
      MODE_SUPER = 2'd1,
      MODE_RSVD  = 2'd2,
      MODE_MACH  = 2'd3
   } pmode_e;

   localparam int unsigned N_CTR     = 32;
   localparam int unsigned N_KINDS   = 3;
   localparam int unsigned STORE_LO  = 32;
   localparam int unsigned N_SLOTS   = 5;
   localparam int unsigned N_IDX     = 40;
   localparam int unsigned SLOT_W    = 3;
   localparam int unsigned SEL_W     = 5;

   localparam int unsigned SLOT_MODE = 0;
   localparam int unsigned SLOT_ISA  = 1;
   localparam int unsigned SLOT_STAT = 2;
   localparam int unsigned SLOT_MEN  = 3;
   localparam int unsigned SLOT_SEN  = 4;

   localparam logic [31:0] ISA_EXT   = 32'h0014_112D;
   localparam logic [31:0] EN_RESET  = 32'h7;
endpackage

// File: rtl/csr_ctr.sv
module csr_ctr #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < 1) begin : g_bad_w
      $error("csr_ctr: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (bump) count <= count + 1'b1;
   end

   a_r7_step_on_bump: assert property (@(posedge clk) disable iff (!rst_n)
      bump |=> count == $past(count) + 1'b1);
   a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !bump |=> $stable(count));
endmodule

// File: rtl/csr_gate.sv
module csr_gate
   import csr_cnt_pkg::*;
(
   input  logic [1:0]       mode,
   input  logic [N_CTR-1:0] sup_mask,
   input  logic [N_CTR-1:0] usr_mask,
   input  logic [SEL_W-1:0] sel,
   output logic             allow
);
   always_comb begin
      unique case (pmode_e'(mode))
         MODE_MACH:  allow = 1'b1;
         MODE_SUPER: allow = sup_mask[sel];
         MODE_USER:  allow = usr_mask[sel];
         default:    allow = 1'b0;
      endcase
   end

   always_comb begin
      if (mode == 2'd2) a_r6_reserved_denies: assert (!allow);
   end
endmodule

// File: rtl/csr_store.sv
module csr_store
   import csr_cnt_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SLOT_W-1:0] slot,
   input  logic [XLEN-1:0]   wdata,
   output logic [XLEN-1:0]   rdata,
   output logic [1:0]        mode_o,
   output logic [N_CTR-1:0]  sup_mask_o,
   output logic [N_CTR-1:0]  usr_mask_o
);
   if (XLEN < 36) begin : g_bad_xlen
      $error("csr_store: XLEN must hold the status width fields");
   end

   logic [XLEN-1:0] mem [N_SLOTS];

   function automatic logic [XLEN-1:0] init_val(int unsigned k);
      case (k)
         SLOT_MODE: return XLEN'(MODE_MACH);
         SLOT_ISA:  return (XLEN'(2) << (XLEN-2)) | XLEN'(ISA_EXT);
         SLOT_STAT: return (XLEN'(2) << 32) | (XLEN'(2) << 34) | (XLEN'(1) << 13);
         SLOT_MEN, SLOT_SEN: return XLEN'(EN_RESET);
         default:   return '0;
      endcase
   endfunction

   for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           mem[k] <= init_val(k);
         else if (we && slot == SLOT_W'(k))    mem[k] <= wdata;
      end

      a_r8_untouched_holds: assert property (@(posedge clk) disable iff (!rst_n)
         !(we && slot == SLOT_W'(k)) |=> $stable(mem[k]));
      a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
         (we && slot == SLOT_W'(k)) |=> mem[k] == $past(wdata));
   end

   always_comb begin
      rdata = '0;
      if (32'(slot) < N_SLOTS) rdata = mem[slot];
   end

   assign mode_o     = mem[SLOT_MODE][1:0];
   assign sup_mask_o = mem[SLOT_MEN][N_CTR-1:0];
   assign usr_mask_o = mem[SLOT_SEN][N_CTR-1:0];
endmodule

// File: rtl/csr_cnt_unit.sv
module csr_cnt_unit
   import csr_cnt_pkg::*;
#(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned CNT_W = 64,
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic [XLEN-1:0]  wr_data,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             retire,
   input  logic             tick,
   output logic [XLEN-1:0]  rd_data,
   output logic             bad_idx
);
   if (CNT_W > XLEN) begin : g_bad_cnt
      $error("csr_cnt_unit: CNT_W may not exceed XLEN");
   end
   if ((64'd1 << IDX_W) < 64'(N_IDX)) begin : g_bad_idx
      $error("csr_cnt_unit: IDX_W too narrow for the index space");
   end

   logic             idx_ok, is_ctr, in_store, allow;
   logic [N_KINDS-1:0] bump;
   logic [CNT_W-1:0] ctr_q [N_KINDS];
   logic [CNT_W-1:0] ctr_pick;
   logic [SEL_W-1:0] sel;
   logic [SLOT_W-1:0] slot;
   logic [XLEN-1:0]  store_rd, rd_next;
   logic [1:0]       mode;
   logic [N_CTR-1:0] sup_mask, usr_mask;

   assign idx_ok   = 32'(acc_idx) < N_IDX;
   assign is_ctr   = 32'(acc_idx) < N_CTR;
   assign in_store = idx_ok && !is_ctr;
   assign sel      = acc_idx[SEL_W-1:0];
   assign slot     = SLOT_W'(32'(acc_idx) - STORE_LO);

   assign bump[0] = 1'b1;
   assign bump[1] = tick;
   assign bump[2] = retire;

   for (genvar k = 0; k < N_KINDS; k++) begin : g_ctr
      csr_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .bump  (bump[k]),
         .count (ctr_q[k])
      );
   end

   csr_store #(.XLEN(XLEN)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (wr_en && in_store),
      .slot       (slot),
      .wdata      (wr_data),
      .rdata      (store_rd),
      .mode_o     (mode),
      .sup_mask_o (sup_mask),
      .usr_mask_o (usr_mask)
   );

   csr_gate u_gate (
      .mode     (mode),
      .sup_mask (sup_mask),
      .usr_mask (usr_mask),
      .sel      (sel),
      .allow    (allow)
   );

   always_comb begin
      unique case (sel)
         SEL_W'(1): ctr_pick = ctr_q[1];
         SEL_W'(2): ctr_pick = ctr_q[2];
         default:   ctr_pick = ctr_q[0];
      endcase
   end

   always_comb begin
      rd_next = '0;
      if (is_ctr)        rd_next = allow ? XLEN'(ctr_pick) : '0;
      else if (in_store) rd_next = store_rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         bad_idx <= 1'b0;
      end else begin
         if (rd_en) rd_data <= rd_next;
         bad_idx <= (rd_en || wr_en) && !idx_ok;
      end
   end

   a_r9_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_en || wr_en) && !idx_ok) |=> bad_idx);
   a_r9_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !idx_ok) |=> rd_data == '0);
   a_r6_denied_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && is_ctr && !allow) |=> rd_data == '0);
   a_r6_machine_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && acc_idx == '0 && mode == 2'd3) |=> rd_data == XLEN'($past(ctr_q[0])));
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
   a_r11_id_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && in_store && 32'(slot) >= N_SLOTS) |=> rd_data == '0);
endmodule

// File: tb/tb_csr_cnt_unit.sv
module tb_csr_cnt_unit;
   localparam int CLK_PERIOD = 10;
   localparam int XL = 64;
   localparam int CW = 8;
   localparam int IW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [IW-1:0] acc_idx = '0;
   logic [XL-1:0] wr_data = '0;
   logic          wr_en = 1'b0, rd_en = 1'b0, retire = 1'b0, tick = 1'b0;
   logic [XL-1:0] rd_data;
   logic          bad_idx;

   int checks = 0, errors = 0;
   string phase = "R1";

   csr_cnt_unit #(.XLEN(XL), .CNT_W(CW), .IDX_W(IW)) dut (
      .clk(clk), .rst_n(rst_n), .acc_idx(acc_idx), .wr_data(wr_data),
      .wr_en(wr_en), .rd_en(rd_en), .retire(retire), .tick(tick),
      .rd_data(rd_data), .bad_idx(bad_idx)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference
   logic [63:0] m_reg [5];
   int          m_cyc, m_time, m_ret;
   logic [63:0] exp_data;
   logic        exp_bad;
   string       exp_tag = "R10";

   function automatic logic [63:0] mexp(int idx);
      int md;
      bit ok;
      if (idx >= 40) return 64'd0;
      if (idx < 32) begin
         md = int'(m_reg[0][1:0]);
         if (md == 3)      ok = 1'b1;
         else if (md == 1) ok = m_reg[3][idx];
         else if (md == 0) ok = m_reg[4][idx];
         else              ok = 1'b0;
         if (!ok) return 64'd0;
         if (idx == 1) return 64'(m_time);
         if (idx == 2) return 64'(m_ret);
         return 64'(m_cyc);
      end
      if (idx < 37) return m_reg[idx-32];
      return 64'd0;
   endfunction

   task automatic model_reset();
      m_reg[0] = 64'd3;
      m_reg[1] = 64'h8000_0000_0014_112D;
      m_reg[2] = 64'h0000_000A_0000_2000;
      m_reg[3] = 64'h7;
      m_reg[4] = 64'h7;
      m_cyc = 0; m_time = 0; m_ret = 0;
      exp_data = '0; exp_bad = 1'b0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else begin
         int idx;
         idx = int'(acc_idx);
         if (rd_en) begin
            exp_data = mexp(idx);
            if (idx >= 40)      exp_tag = "R9";
            else if (idx < 32)  exp_tag = "R6";
            else if (idx < 37)  exp_tag = "R8";
            else                exp_tag = "R11";
         end
         exp_bad = (rd_en || wr_en) && idx >= 40;
         if (wr_en && idx >= 32 && idx < 37) m_reg[idx-32] = wr_data;
         m_cyc = (m_cyc + 1) % (1 << CW);
         if (tick)   m_time = (m_time + 1) % (1 << CW);
         if (retire) m_ret  = (m_ret + 1) % (1 << CW);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (rd_data !== exp_data || bad_idx !== exp_bad) begin
            errors++;
            $display("FAIL %s/%s: rd_data=%h bad_idx=%b expected %h %b",
                     phase, exp_tag, rd_data, bad_idx, exp_data, exp_bad);
         end
      end
   end

   task automatic op(int idx, logic [63:0] d, bit w, bit r);
      @(negedge clk);
      acc_idx = IW'(idx); wr_data = d; wr_en = w; rd_en = r;
   endtask

   task automatic idle();
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic do_reset();
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (rd_data !== '0 || bad_idx !== 1'b0) begin
         errors++;
         $display("FAIL R1: after reset rd_data=%h bad_idx=%b expected 0 0", rd_data, bad_idx);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      phase = "R1 R2 R3 R4 R11";
      for (int i = 32; i < 40; i++) op(i, 0, 0, 1);
      phase = "R5 R7";
      for (int i = 0; i < 32; i++) op(i, 0, 0, 1);
      phase = "R9";
      op(40, 0, 0, 1); op(63, 0, 0, 1); op(45, '1, 1, 0); idle(); op(50, 0, 1, 1);
      phase = "R8";
      op(0, '1, 1, 0); op(2, 64'h55, 1, 0); op(37, '1, 1, 0);
      op(0, 0, 0, 1); op(2, 0, 0, 1); op(37, 0, 0, 1);
      op(34, 64'hDEAD_BEEF_0123_4567, 1, 0); op(34, 0, 0, 1);
      phase = "R6 supervisor";
      op(35, 64'h5, 1, 0); op(32, 64'h1, 1, 0);
      for (int i = 0; i < 5; i++) op(i, 0, 0, 1);
      op(35, 64'hD, 1, 0); op(3, 0, 0, 1); op(31, 0, 0, 1);
      phase = "R6 user";
      op(36, 64'h2, 1, 0); op(32, 64'h0, 1, 0);
      for (int i = 0; i < 3; i++) op(i, 0, 0, 1);
      phase = "R6 reserved";
      op(32, 64'h2, 1, 0);
      for (int i = 0; i < 6; i++) op(i, 0, 0, 1);
      phase = "R10";
      op(32, 64'h3, 1, 0);
      op(32, 64'h1, 1, 1); idle(); idle(); op(32, 0, 0, 1);
      op(32, 64'h3, 1, 0);
      phase = "R7 random";
      for (int n = 0; n < 1500; n++) begin
         int idx;
         logic [63:0] d;
         idx = int'($urandom_range(0, 63));
         if (($urandom & 3) != 0) idx = int'($urandom_range(0, 39));
         d = {$urandom, $urandom};
         @(negedge clk);
         tick = $urandom_range(0, 1) == 1;
         retire = $urandom_range(0, 2) == 0;
         acc_idx = IW'(idx); wr_data = d;
         wr_en = $urandom_range(0, 3) == 0;
         rd_en = $urandom_range(0, 2) != 0;
      end
      @(negedge clk);
      tick = 1'b0; retire = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      phase = "R1 second reset";
      do_reset();
      for (int i = 0; i < 40; i++) op(i, 0, 0, 1);
      idle(); idle();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule